// File: doc/BRIEF.md
# Line PLL Loop-Mode Controller

This block chooses how hard the first horizontal phase-locked loop pulls toward the incoming sync. Several status flags describe the signal: whether video is identified, whether the loop is locked, whether the signal is noisy, and whether an external source is selected. From these the block selects one of three loop modes: very slow, slow or fast. For the selected mode it gives the phase-detector charge current in microamps for scan lines and for vertical-retrace lines, and the current that applies on the present line. In slow mode it also gives a gate pulse that lets the phase detector see only a short window around each sync.

The decision is taken only at a line boundary, which is marked by the horizontal sync strobe, so the current never changes part-way through a line. A free-running line timer restarts on every strobe. It opens the gate a fixed number of clocks before the next expected strobe and closes it a fixed number of clocks after that strobe, so the window is centred on sync. With a 10 MHz timing clock, the default 57-clock window is 5.7 µs wide.

Top module: `line_pll_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (very slow), cur_ua_o is 6 and gate_o is 0.
- R2: At a strobe with vid_ok_i low, the next mode is very slow (code 0): scan and retrace currents are both 6. This rule overrides every other input.
- R3: At a strobe with video present and locked_i low, the next mode is fast (code 2): scan current 180, retrace current 270.
- R4: At a strobe with video present, loop locked, noise_i high and ext_src_i low, the next mode is slow (code 1): scan and retrace currents are both 30.
- R5: With ext_src_i high and video present, slow mode is never chosen. The mode is fast even when noise_i is high.
- R6: At a strobe with video present, loop locked and noise_i low, the next mode is fast (code 2).
- R7: cur_ua_o equals the retrace current of the new mode when vretrace_i is high at the strobe, and the scan current otherwise. It therefore exceeds the scan current only in fast mode.
- R8: mode_o and cur_ua_o change only in the clock after a cycle in which hsync_stb_i is high.
- R9: gate_o is high only in slow mode. For strobes spaced LINE_CYC clocks apart, it is high for GATE_CYC consecutive clocks: GATE_CYC/2 clocks before the strobe clock through the clocks after it. It is high in the clock after a strobe that selects slow mode.
- R10: Mode codes are 0 = very slow, 1 = slow, 2 = fast. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| noise_i | input | 1 | Weak or noisy signal detected |
| vid_ok_i | input | 1 | Video identified |
| locked_i | input | 1 | Line loop synchronized |
| ext_src_i | input | 1 | External video source selected |
| vretrace_i | input | 1 | Vertical retrace interval active |
| hsync_stb_i | input | 1 | One-clock strobe at the sync centre, marks a line boundary |
| mode_o | output | 2 | Loop mode code |
| scan_ua_o | output | UA_W | Scan-line current of the present mode, in µA |
| retr_ua_o | output | UA_W | Retrace-line current of the present mode, in µA |
| cur_ua_o | output | UA_W | Current applied on the present line, in µA |
| gate_o | output | 1 | Phase-detector gate window |

## Verification
On every cycle, the assertions check that the mode and the applied current hold steady between strobes. They also check that the priority rule at each strobe holds: missing video forces very slow, and either a lost lock or an external source forces fast. Further cycle checks cover the boost appearing only in fast mode, the gate opening after a strobe that selects slow mode, and the unused mode code. Only the bench's line-by-line scenarios can show the width and centring of the gate window, since they depend on regular strobe spacing. The same holds for the retrace boost following vretrace_i at the boundary, and for the full current table of each mode.

// File: rtl/lpll_pkg.sv
package lpll_pkg;
  typedef enum logic [1:0] {
    LM_VSLOW = 2'd0,
    LM_SLOW  = 2'd1,
    LM_FAST  = 2'd2
  } loop_mode_e;

  localparam int unsigned UA_W         = 9;
  localparam int unsigned UA_VSLOW     = 6;
  localparam int unsigned UA_SLOW      = 30;
  localparam int unsigned UA_FAST_SCAN = 180;
  localparam int unsigned UA_FAST_RETR = 270;
endpackage

// File: rtl/lpll_mode_sel.sv
module lpll_mode_sel
  import lpll_pkg::*;
(
  input  logic       vid_ok_i,
  input  logic       locked_i,
  input  logic       noise_i,
  input  logic       ext_src_i,
  output loop_mode_e mode_o
);
  always_comb begin
    if (!vid_ok_i)                   mode_o = LM_VSLOW;
    else if (!locked_i)              mode_o = LM_FAST;
    else if (noise_i && !ext_src_i)  mode_o = LM_SLOW;
    else                             mode_o = LM_FAST;
  end
endmodule

// File: rtl/lpll_cur_map.sv
module lpll_cur_map
  import lpll_pkg::*;
#(
  parameter int unsigned W = UA_W
) (
  input  loop_mode_e     mode_i,
  output logic [W-1:0]   scan_o,
  output logic [W-1:0]   retr_o
);
  always_comb begin
    unique case (mode_i)
      LM_SLOW: begin
        scan_o = W'(UA_SLOW);
        retr_o = W'(UA_SLOW);
      end
      LM_FAST: begin
        scan_o = W'(UA_FAST_SCAN);
        retr_o = W'(UA_FAST_RETR);
      end
      default: begin
        scan_o = W'(UA_VSLOW);
        retr_o = W'(UA_VSLOW);
      end
    endcase
  end
endmodule

// File: rtl/lpll_line_timer.sv
module lpll_line_timer #(
  parameter int unsigned LINE_CYC = 640,
  parameter int unsigned GATE_CYC = 57
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic win_o
);
  localparam int unsigned CW      = $clog2(LINE_CYC);
  localparam int unsigned HALF_LO = GATE_CYC / 2;
  localparam int unsigned HALF_HI = GATE_CYC - HALF_LO;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (stb_i)                         cnt_q <= '0;
    else if (cnt_q == CW'(LINE_CYC - 1))    cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end

  // open before the expected strobe, close after it
  assign win_o = (cnt_q < CW'(HALF_HI)) || (cnt_q >= CW'(LINE_CYC - HALF_LO));
endmodule

// File: rtl/line_pll_mode_ctrl.sv
module line_pll_mode_ctrl
  import lpll_pkg::*;
#(
  parameter int unsigned LINE_CYC = 640,
  parameter int unsigned GATE_CYC = 57,
  parameter int unsigned CUR_W    = UA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             noise_i,
  input  logic             vid_ok_i,
  input  logic             locked_i,
  input  logic             ext_src_i,
  input  logic             vretrace_i,
  input  logic             hsync_stb_i,
  output logic [1:0]       mode_o,
  output logic [CUR_W-1:0] scan_ua_o,
  output logic [CUR_W-1:0] retr_ua_o,
  output logic [CUR_W-1:0] cur_ua_o,
  output logic             gate_o
);
  loop_mode_e       mode_nxt, mode_q;
  logic [CUR_W-1:0] nxt_scan, nxt_retr;
  logic [CUR_W-1:0] cur_q;
  logic             win;

  lpll_mode_sel u_sel (
    .vid_ok_i  (vid_ok_i),
    .locked_i  (locked_i),
    .noise_i   (noise_i),
    .ext_src_i (ext_src_i),
    .mode_o    (mode_nxt)
  );

  lpll_cur_map #(.W(CUR_W)) u_map_nxt (
    .mode_i (mode_nxt),
    .scan_o (nxt_scan),
    .retr_o (nxt_retr)
  );

  lpll_cur_map #(.W(CUR_W)) u_map_cur (
    .mode_i (mode_q),
    .scan_o (scan_ua_o),
    .retr_o (retr_ua_o)
  );

  lpll_line_timer #(.LINE_CYC(LINE_CYC), .GATE_CYC(GATE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (hsync_stb_i),
    .win_o  (win)
  );

  // decisions land only at line boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LM_VSLOW;
      cur_q  <= CUR_W'(UA_VSLOW);
    end else if (hsync_stb_i) begin
      mode_q <= mode_nxt;
      cur_q  <= vretrace_i ? nxt_retr : nxt_scan;
    end
  end

  assign mode_o   = mode_q;
  assign cur_ua_o = cur_q;
  assign gate_o   = (mode_q == LM_SLOW) && win;
endmodule

// File: rtl/line_pll_mode_ctrl_sva.sv
module line_pll_mode_ctrl_sva
  import lpll_pkg::*;
#(
  parameter int unsigned CUR_W = UA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             noise_i,
  input logic             vid_ok_i,
  input logic             locked_i,
  input logic             ext_src_i,
  input logic             hsync_stb_i,
  input logic [1:0]       mode_o,
  input logic [CUR_W-1:0] scan_ua_o,
  input logic [CUR_W-1:0] cur_ua_o,
  input logic             gate_o
);
  a_r8_hold_midline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_stb_i |=> $stable(mode_o) && $stable(cur_ua_o));

  a_r2_no_video: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_stb_i && !vid_ok_i |=> mode_o == 2'd0 && cur_ua_o == CUR_W'(UA_VSLOW));

  a_r3_unlocked_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_stb_i && vid_ok_i && !locked_i |=> mode_o == 2'd2);

  a_r5_ext_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_stb_i && vid_ok_i && ext_src_i |=> mode_o == 2'd2);

  a_r7_boost_fast_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ua_o > scan_ua_o |-> mode_o == 2'd2);

  a_r9_gate_after_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_stb_i && vid_ok_i && locked_i && noise_i && !ext_src_i |=> gate_o);

  a_r10_code_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

bind line_pll_mode_ctrl line_pll_mode_ctrl_sva #(.CUR_W(CUR_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .noise_i     (noise_i),
  .vid_ok_i    (vid_ok_i),
  .locked_i    (locked_i),
  .ext_src_i   (ext_src_i),
  .hsync_stb_i (hsync_stb_i),
  .mode_o      (mode_o),
  .scan_ua_o   (scan_ua_o),
  .cur_ua_o    (cur_ua_o),
  .gate_o      (gate_o)
);

// File: tb/line_pll_mode_ctrl_tb.sv
module line_pll_mode_ctrl_tb;
  localparam int LINE = 100;
  localparam int GATE = 21;
  localparam int W    = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic noise = 1'b0, vid = 1'b0, lock = 1'b0, ext = 1'b0, vr = 1'b0, hs = 1'b0;
  logic [1:0]   mode;
  logic [W-1:0] scan, retr, cur;
  logic         gate;

  line_pll_mode_ctrl #(.LINE_CYC(LINE), .GATE_CYC(GATE), .CUR_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .noise_i(noise), .vid_ok_i(vid),
    .locked_i(lock), .ext_src_i(ext), .vretrace_i(vr), .hsync_stb_i(hs),
    .mode_o(mode), .scan_ua_o(scan), .retr_ua_o(retr), .cur_ua_o(cur), .gate_o(gate)
  );

  typedef struct {
    int    m;
    int    cu;
    int    sc;
    int    rt;
    int    g;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   gcnt = 0;
  int   prev_mode = 0;
  logic hs_seen = 1'b0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: one line, strobe on its last clock, expected item queued
  task automatic run_line(bit v, bit l, bit n, bit e, bit r, string tag);
    exp_t it;
    int   m;
    @(negedge clk);
    vid = v; lock = l; noise = n; ext = e; vr = r; hs = 1'b0;
    m = !v ? 0 : (!l ? 2 : ((n && !e) ? 1 : 2));
    for (int k = 1; k < LINE; k++) begin
      @(negedge clk);
      if (k == 50) chk(int'(mode) == prev_mode, "R8 mid-line mode", int'(mode), prev_mode);
      if (k == LINE - 1) begin
        if (prev_mode == 1) chk(gate == 1'b1, "R9 gate open before strobe", int'(gate), 1);
        hs = 1'b1;
      end
    end
    it.m   = m;
    it.sc  = (m == 0) ? 6 : ((m == 1) ? 30 : 180);
    it.rt  = (m == 0) ? 6 : ((m == 1) ? 30 : 270);
    it.cu  = r ? it.rt : it.sc;
    it.g   = (prev_mode == 1) ? GATE : 0;
    it.tag = tag;
    q.push_back(it);
    prev_mode = m;
  endtask

  always @(posedge clk) hs_seen <= hs;

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (hs_seen) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected strobe", 0, 1);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(int'(mode) == it.m,  {it.tag, " R10 mode code"}, int'(mode), it.m);
          chk(int'(scan) == it.sc, {it.tag, " scan current"}, int'(scan), it.sc);
          chk(int'(retr) == it.rt, {it.tag, " retrace current"}, int'(retr), it.rt);
          chk(int'(cur)  == it.cu, {it.tag, " R7 applied current"}, int'(cur), it.cu);
          chk(gcnt == it.g, "R9 gate width", gcnt, it.g);
        end
        gcnt = 0;
      end
      if (gate) gcnt++;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R1 reset mode", int'(mode), 0);
    chk(int'(cur) == 6, "R1 reset current", int'(cur), 6);
    chk(gate == 1'b0, "R1 reset gate", int'(gate), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0, "R1 mode after release", int'(mode), 0);

    run_line(0, 1, 0, 0, 0, "R2");
    run_line(1, 0, 0, 0, 0, "R3");
    run_line(1, 0, 0, 0, 1, "R3 R7 retrace boost");
    run_line(1, 1, 1, 0, 0, "R4");
    run_line(1, 1, 1, 0, 1, "R4 R7 no boost in slow");
    run_line(1, 1, 1, 1, 0, "R5");
    run_line(1, 1, 1, 1, 1, "R5 R7");
    run_line(1, 1, 0, 0, 0, "R6");
    run_line(1, 0, 1, 0, 0, "R3 noisy unlocked");
    run_line(0, 1, 1, 0, 1, "R2 R7 no video retrace");
    run_line(1, 1, 1, 0, 0, "R4");
    run_line(1, 1, 1, 0, 0, "R4 R9 steady");
    run_line(0, 0, 1, 1, 0, "R2 priority");
    run_line(1, 1, 0, 0, 1, "R6 R7");
    @(negedge clk);
    hs = 1'b0;
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R8 all lines seen", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule